// File: doc/BRIEF.md
# Service Request Controller with Mask and Enable Gate

This block gathers service requests from a module's event sources into a 16-bit request register and raises one request line toward the host. Each bit has a fixed class. Three bits latch on a one-cycle event pulse and stay set until the host clears them. Three bits mirror live conditions. One bit is set only by a host command. The remaining bits are unused and always read zero.

A 16-bit mask register and a global enable gate decide whether the request line follows the stored bits. The host drives commands as a function code and a subaddress, qualified by a valid strobe. The commands read and write the request and mask registers, clear the request register in full or bit by bit, set the software bit, open or close the gate, and ask whether the request line is currently asserted. Latched bits keep collecting while the gate is closed, so they raise the line once the host opens it.

Top module: `srq_ctrl`

## Requirements
- R1: After synchronous reset the request register, the mask register and the enable gate are all zero, `srq_line` is 0 and `rd_data` is 0.
- R2: Bits 2, 3 and 4 are latched: a 1 on `evt_pulse` at a clock edge sets the bit, and it stays set until a clear or a register write changes it.
- R3: Bits 0, 1 and 5 are live: each edge loads them from `live_cond`, and no clear or write command changes them.
- R4: Function 14, subaddress 0 sets bit 15, which then stays set until a clear or a register write changes it. `evt_pulse` has no effect on bit 15.
- R5: Function 10, subaddress 0 clears every latched bit and bit 15.
- R6: Function 19, subaddress 12 clears each latched bit, and bit 15, wherever `cmd_wdata` holds a 1. Other bits keep their value.
- R7: When a clear command and an event pulse hit the same latched bit at the same edge, the bit ends up set.
- R8: `srq_line` is 1 exactly when the gate is open and some request bit is 1 while its mask bit is 1. A mask bit of 1 lets its source through.
- R9: Function 26, subaddress 15 opens the gate, and function 24, subaddress 15 closes it. Requests latch while the gate is closed and raise `srq_line` once it opens.
- R10: Function 8, subaddress 0 makes `q_resp` 1 in the next cycle if `srq_line` was 1 when the command was taken. `q_resp` is 0 in every other cycle.
- R11: Function 6, subaddress 14 returns the request register and function 6, subaddress 13 returns the mask register on `rd_data` in the next cycle. `rd_data` holds its value otherwise.
- R12: Function 19, subaddress 13 loads all 16 mask bits from `cmd_wdata`. Function 19, subaddress 14 loads only the latched bits and bit 15 from `cmd_wdata`.
- R13: Bits 6 to 14 always read 0. `evt_pulse` on bits 0, 1 and 5 to 15 has no effect.
- R14: A command with `cmd_valid` low, or with an unlisted function and subaddress pair, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Qualifies the host command for this cycle |
| cmd_func | input | 5 | Host function code |
| cmd_sub | input | 4 | Host subaddress |
| cmd_wdata | input | 16 | Host write data or bit mask |
| evt_pulse | input | 16 | One-cycle event pulses for the latched bits |
| live_cond | input | 16 | Live condition levels for the live bits |
| srq_line | output | 1 | Module service request line |
| q_resp | output | 1 | Response to the check command |
| rd_data | output | 16 | Register read data |

## Verification
Every result of this block is due exactly one cycle after the stimulus that causes it:
- An event, a live level or a command taken at an edge shows up in the request, mask and gate state right after that edge.
- `srq_line` follows that state through logic alone.
- `q_resp` and `rd_data` are registered one edge after the check or read command.

The bench driver applies each stimulus on a falling edge and queues each expected item with the cycle number in which it is due. The monitor compares items only on the falling edge of their due cycle. Corner cases such as a clear colliding with an event, or a write trying to reach a live bit, are then confirmed by a read on the next cycle.

// File: rtl/srq_pkg.sv
package srq_pkg;

    localparam int unsigned SRQ_W = 16;
    localparam int unsigned FN_W  = 5;
    localparam int unsigned SA_W  = 4;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD_REQ,
        OP_RD_MASK,
        OP_WR_REQ,
        OP_WR_MASK,
        OP_CLR_ALL,
        OP_CLR_SEL,
        OP_SET_SOFT,
        OP_ENABLE,
        OP_DISABLE,
        OP_CHECK
    } srq_op_e;

    function automatic srq_op_e srq_op_of(input logic [FN_W-1:0] fn,
                                          input logic [SA_W-1:0] sa);
        srq_op_e op;
        case ({fn, sa})
            {5'd6,  4'd14}: op = OP_RD_REQ;
            {5'd6,  4'd13}: op = OP_RD_MASK;
            {5'd19, 4'd14}: op = OP_WR_REQ;
            {5'd19, 4'd13}: op = OP_WR_MASK;
            {5'd10, 4'd0 }: op = OP_CLR_ALL;
            {5'd19, 4'd12}: op = OP_CLR_SEL;
            {5'd14, 4'd0 }: op = OP_SET_SOFT;
            {5'd26, 4'd15}: op = OP_ENABLE;
            {5'd24, 4'd15}: op = OP_DISABLE;
            {5'd8,  4'd0 }: op = OP_CHECK;
            default:        op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/srq_decode.sv
module srq_decode
    import srq_pkg::*;
(
    input  logic            cmd_valid,
    input  logic [FN_W-1:0] cmd_func,
    input  logic [SA_W-1:0] cmd_sub,
    output srq_op_e         op
);
    always_comb begin
        op = OP_NONE;
        if (cmd_valid) begin
            op = srq_op_of(cmd_func, cmd_sub);
        end
    end
endmodule

// File: rtl/srq_store.sv
module srq_store
    import srq_pkg::*;
#(
    parameter int unsigned     W          = SRQ_W,
    parameter logic [W-1:0]    LATCH_BITS = W'(16'h001C),
    parameter logic [W-1:0]    LIVE_BITS  = W'(16'h0023),
    parameter int unsigned     SOFT_IDX   = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  srq_op_e      op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt_pulse,
    input  logic [W-1:0] live_cond,
    output logic [W-1:0] req_q
);
    localparam logic [W-1:0] SOFT_SEL = {{(W-1){1'b0}}, 1'b1} << SOFT_IDX;

    logic wr_req;
    logic clr_all;
    logic clr_sel;
    logic set_soft;

    assign wr_req   = (op == OP_WR_REQ);
    assign clr_all  = (op == OP_CLR_ALL);
    assign clr_sel  = (op == OP_CLR_SEL);
    assign set_soft = (op == OP_SET_SOFT);

    for (genvar i = 0; i < int'(W); i++) begin : g_bit
        if (i == int'(SOFT_IDX)) begin : g_soft
            logic b_q;
            logic clr_i;
            assign clr_i = clr_all | (clr_sel & wdata[i]);
            always_ff @(posedge clk) begin
                if (rst) b_q <= 1'b0;
                else     b_q <= set_soft | (wr_req ? wdata[i] : (b_q & ~clr_i));
            end
            assign req_q[i] = b_q;
            // R4: the set command always leaves the software bit on
            p_soft_set_r4: assert property (@(posedge clk) disable iff (rst)
                set_soft |=> req_q[i]);
        end else if (LATCH_BITS[i]) begin : g_latch
            logic b_q;
            logic clr_i;
            assign clr_i = clr_all | (clr_sel & wdata[i]);
            always_ff @(posedge clk) begin
                if (rst) b_q <= 1'b0;
                else     b_q <= evt_pulse[i] | (wr_req ? wdata[i] : (b_q & ~clr_i));
            end
            assign req_q[i] = b_q;
            // R7: an event wins over any clear in the same cycle
            p_evt_wins_r7: assert property (@(posedge clk) disable iff (rst)
                evt_pulse[i] |=> req_q[i]);
            // R2: a set latched bit stays set without clear or write
            p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
                (req_q[i] && !wr_req && !clr_all && !clr_sel) |=> req_q[i]);
        end else if (LIVE_BITS[i]) begin : g_live
            logic b_q;
            always_ff @(posedge clk) begin
                if (rst) b_q <= 1'b0;
                else     b_q <= live_cond[i];
            end
            assign req_q[i] = b_q;
        end else begin : g_none
            assign req_q[i] = 1'b0;
        end
    end

    logic unused_ok;
    assign unused_ok = ^{wdata & ~(LATCH_BITS | SOFT_SEL),
                         evt_pulse & ~(LATCH_BITS & ~SOFT_SEL),
                         live_cond & ~LIVE_BITS};
endmodule

// File: rtl/srq_gate.sv
module srq_gate
    import srq_pkg::*;
#(
    parameter int unsigned W = SRQ_W
) (
    input  logic         clk,
    input  logic         rst,
    input  srq_op_e      op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] req_q,
    output logic         srq_line,
    output logic         q_resp,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] mask_q;
    logic         en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            en_q    <= 1'b0;
            q_resp  <= 1'b0;
            rd_data <= '0;
        end else begin
            q_resp <= 1'b0;
            unique case (op)
                OP_WR_MASK: mask_q  <= wdata;
                OP_ENABLE:  en_q    <= 1'b1;
                OP_DISABLE: en_q    <= 1'b0;
                OP_CHECK:   q_resp  <= srq_line;
                OP_RD_REQ:  rd_data <= req_q;
                OP_RD_MASK: rd_data <= mask_q;
                default:    ;
            endcase
        end
    end

    assign srq_line = en_q & (|(req_q & mask_q));

    // R9: closing the gate silences the line on the next cycle
    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DISABLE) |=> !srq_line);
    // R10: the check answer mirrors the line at the command
    p_q_check_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CHECK) |=> (q_resp == $past(srq_line)));
    // R10: no answer without a check
    p_q_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (op != OP_CHECK) |=> !q_resp);
    // R11: read data holds when no read is taken
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (op != OP_RD_REQ && op != OP_RD_MASK) |=> $stable(rd_data));
endmodule

// File: rtl/srq_ctrl.sv
module srq_ctrl
    import srq_pkg::*;
#(
    parameter int unsigned  W          = SRQ_W,
    parameter logic [W-1:0] LATCH_BITS = W'(16'h001C),
    parameter logic [W-1:0] LIVE_BITS  = W'(16'h0023),
    parameter int unsigned  SOFT_IDX   = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [FN_W-1:0] cmd_func,
    input  logic [SA_W-1:0] cmd_sub,
    input  logic [W-1:0]    cmd_wdata,
    input  logic [W-1:0]    evt_pulse,
    input  logic [W-1:0]    live_cond,
    output logic            srq_line,
    output logic            q_resp,
    output logic [W-1:0]    rd_data
);
    srq_op_e      op;
    logic [W-1:0] req_q;

    srq_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_func  (cmd_func),
        .cmd_sub   (cmd_sub),
        .op        (op)
    );

    srq_store #(
        .W          (W),
        .LATCH_BITS (LATCH_BITS),
        .LIVE_BITS  (LIVE_BITS),
        .SOFT_IDX   (SOFT_IDX)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wdata     (cmd_wdata),
        .evt_pulse (evt_pulse),
        .live_cond (live_cond),
        .req_q     (req_q)
    );

    srq_gate #(
        .W (W)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wdata    (cmd_wdata),
        .req_q    (req_q),
        .srq_line (srq_line),
        .q_resp   (q_resp),
        .rd_data  (rd_data)
    );

    // R13: unused positions never carry a request
    p_unused_zero_r13: assert property (@(posedge clk) disable iff (rst)
        (req_q & ~(LATCH_BITS | LIVE_BITS | ({{(W-1){1'b0}}, 1'b1} << SOFT_IDX))) == '0);
endmodule

// File: tb/srq_ctrl_bench.sv
`timescale 1ns/1ps
module srq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [4:0]  cmd_func = '0;
    logic [3:0]  cmd_sub = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] evt_pulse = '0;
    logic [15:0] live_cond = '0;
    logic        srq_line;
    logic        q_resp;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    srq_ctrl u_srq_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata), .evt_pulse(evt_pulse),
        .live_cond(live_cond), .srq_line(srq_line), .q_resp(q_resp),
        .rd_data(rd_data)
    );

    typedef struct {
        int          due;
        int          kind;   // 0 line, 1 q, 2 read data
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void expect_at(int kind, logic [15:0] v, string tag);
        exp_t e;
        e.due = cyc + 1; e.kind = kind; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endfunction

    // monitor: compares every item on the falling edge of its due cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t        e;
            logic [15:0] act;
            e = sbq.pop_front();
            act = (e.kind == 0) ? {15'd0, srq_line} :
                  (e.kind == 1) ? {15'd0, q_resp} : rd_data;
            checks++;
            if (act !== e.val) begin
                errors++;
                $display("FAIL %s kind %0d: actual %h expected %h", e.tag, e.kind, act, e.val);
            end
        end
    end

    task automatic drive(input logic v, input logic [4:0] f, input logic [3:0] s,
                         input logic [15:0] d, input logic [15:0] e);
        @(negedge clk);
        cmd_valid = v; cmd_func = f; cmd_sub = s; cmd_wdata = d; evt_pulse = e;
    endtask

    task automatic idle();
        drive(1'b0, 5'd0, 4'd0, 16'h0, 16'h0);
    endtask

    task automatic rd_req(input logic [15:0] v, input string tag);
        drive(1'b1, 5'd6, 4'd14, 16'h0, 16'h0);
        expect_at(2, v, tag);
    endtask

    task automatic rd_mask(input logic [15:0] v, input string tag);
        drive(1'b1, 5'd6, 4'd13, 16'h0, 16'h0);
        expect_at(2, v, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_req(16'h0000, "R1 request after reset");
        expect_at(0, 16'h0, "R1 line after reset");
        rd_mask(16'h0000, "R1 mask after reset");
        // R12 mask write
        drive(1'b1, 5'd19, 4'd13, 16'hFFFF, 16'h0);
        rd_mask(16'hFFFF, "R12 mask write");
        // R2 latched events, R9 gate closed
        drive(1'b0, 5'd0, 4'd0, 16'h0, 16'h001C);
        expect_at(0, 16'h0, "R9 line off while gate closed");
        rd_req(16'h001C, "R2 latched bits set");
        idle(); idle();
        rd_req(16'h001C, "R2 latched bits held");
        // R9 open gate
        drive(1'b1, 5'd26, 4'd15, 16'h0, 16'h0);
        expect_at(0, 16'h1, "R9 line fires once gate opens");
        // R10 check
        drive(1'b1, 5'd8, 4'd0, 16'h0, 16'h0);
        expect_at(1, 16'h1, "R10 check with request");
        idle();
        expect_at(1, 16'h0, "R10 q only after check");
        // R6 clear selected
        drive(1'b1, 5'd19, 4'd12, 16'h0004, 16'h0);
        rd_req(16'h0018, "R6 clear selected");
        // R7 clear all collides with event
        drive(1'b1, 5'd10, 4'd0, 16'h0, 16'h0008);
        expect_at(0, 16'h1, "R7 line still set");
        rd_req(16'h0008, "R7 event wins over clear");
        // R5 clear all
        drive(1'b1, 5'd10, 4'd0, 16'h0, 16'h0);
        expect_at(0, 16'h0, "R5 line off after clear all");
        rd_req(16'h0000, "R5 clear all");
        drive(1'b1, 5'd8, 4'd0, 16'h0, 16'h0);
        expect_at(1, 16'h0, "R10 check without request");
        // R3 live bits
        idle(); live_cond = 16'h0023;
        expect_at(0, 16'h1, "R3 live bits raise line");
        drive(1'b1, 5'd10, 4'd0, 16'h0, 16'h0);
        rd_req(16'h0023, "R3 clear does not touch live bits");
        live_cond = 16'h0000;
        expect_at(0, 16'h0, "R3 line drops with live condition");
        rd_req(16'h0000, "R3 live bits follow condition");
        // R13 events on non-latched positions
        drive(1'b0, 5'd0, 4'd0, 16'h0, 16'hFFE3);
        expect_at(0, 16'h0, "R13 line unaffected");
        rd_req(16'h0000, "R13 stray events ignored");
        // R4 software bit
        drive(1'b1, 5'd14, 4'd0, 16'h0, 16'h0);
        expect_at(0, 16'h1, "R4 software bit raises line");
        rd_req(16'h8000, "R4 software bit set");
        // R8 masking
        drive(1'b1, 5'd19, 4'd13, 16'h0004, 16'h0);
        expect_at(0, 16'h0, "R8 masked bit does not raise line");
        drive(1'b0, 5'd0, 4'd0, 16'h0, 16'h0004);
        expect_at(0, 16'h1, "R8 unmasked bit raises line");
        // R9 close gate, requests kept
        drive(1'b1, 5'd24, 4'd15, 16'h0, 16'h0);
        expect_at(0, 16'h0, "R9 line off after close");
        rd_req(16'h8004, "R9 requests kept while closed");
        // R12 request write reaches only writable bits
        drive(1'b1, 5'd19, 4'd14, 16'hFFFF, 16'h0);
        rd_req(16'h801C, "R12 request write limited");
        // R14 ignored commands
        drive(1'b0, 5'd10, 4'd0, 16'h0, 16'h0);
        drive(1'b1, 5'd7, 4'd0, 16'hFFFF, 16'h0);
        drive(1'b1, 5'd19, 4'd5, 16'h0000, 16'h0);
        rd_req(16'h801C, "R14 request untouched");
        rd_mask(16'h0004, "R14 mask untouched");
        // R11 read data holds
        idle();
        expect_at(2, 16'h0004, "R11 read data holds");
        idle(); idle(); idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule